// File: doc/BRIEF.md
# Look-Up Table Storage Cell with RAM and Shift Modes

This block is one storage array of single-bit entries that can be used in three ways. As a look-up table it returns the entry that the address points to, with no clock in the read path. As a small RAM it keeps that combinational read path and adds a one-bit synchronous write. As a serial shift register it moves the whole array up by one place on each enabled clock. In that mode the address picks a tap, so the block works as a delay line whose length can change. A fixed output always carries the top entry of the array, so that further cells can be chained after it.

The array is made of one or two cells of 32 entries each. When there are two cells, the top address bit chooses the cell, which gives a 64-entry RAM. In shift mode the top entry of the lower cell feeds the bottom entry of the upper cell. The contents after reset come from a parameter. A two-bit mode input picks the operation, and changing it never changes the stored bits.

Top module: `lut_dram_cell`

## Requirements
- R1: While reset is low, and after it is released, the array holds the INIT parameter. In mode 2'b00 (look-up), rd_data equals entry addr of the array, and it follows a change of addr in the same cycle.
- R2: In mode 2'b01 (RAM), wr_en high at a rising clock edge stores wr_data into entry addr. From that edge on, rd_data at that address shows the new value.
- R3: In modes 2'b00 and 2'b11 (both look-up), wr_en leaves every entry unchanged.
- R4: A RAM write changes only the addressed entry. Address bit CELL_AW (bit 5 by default) selects the upper or the lower cell.
- R5: In mode 2'b10 (shift), each rising edge with wr_en high moves entry i to entry i+1 across both cells and loads wr_data into entry 0. rd_data is the entry at addr, so a tap at address k returns the input given k enabled edges earlier.
- R6: casc_out always equals the top entry of the whole array (entry 63 by default).
- R7: With wr_en low, no entry changes in any mode.
- R8: Changing mode keeps every stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and shifts happen on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads the INIT contents |
| mode | input | 2 | 00 look-up, 01 RAM, 10 shift, 11 look-up |
| addr | input | ADDR_W (6) | Read address, write address or shift tap |
| wr_en | input | 1 | Write strobe in RAM mode, shift enable in shift mode |
| wr_data | input | 1 | Bit to write, or the serial input |
| rd_data | output | 1 | Combinational read of the addressed entry |
| casc_out | output | 1 | Top entry of the array, for chaining |

## Verification
On every cycle, the assertions check how the contents change between clock edges. A RAM write must land at the past address and must flip no more than one entry. A shift must move the whole vector by one place and take in the serial bit. In look-up modes, or with the enable low, the array must hold still. The cascade output must follow the entry just below the top after a shift. The bench's sweeps are the only way to show that the read path is combinational and uses the right bit order. The same goes for the INIT contents after reset, that the upper-address bit picks the right cell for writes, and that delay-line taps return inputs from the right number of edges earlier.

// File: rtl/lut_dram_pkg.sv
package lut_dram_pkg;

   typedef enum logic [1:0] {
      MODE_LUT   = 2'b00,
      MODE_RAM   = 2'b01,
      MODE_SHIFT = 2'b10,
      MODE_LUT2  = 2'b11
   } cell_mode_e;

endpackage

// File: rtl/lut_dram_csel.sv
// One-hot cell enable from the upper address bits.
module lut_dram_csel #(
   parameter int CELLS = 2,
   parameter int HI_W  = 1
) (
   input  logic [HI_W-1:0]  hi_addr,
   input  logic             en,
   output logic [CELLS-1:0] sel
);
   generate
      if (CELLS == 1) begin : g_single
         logic unused_hi;
         assign unused_hi = ^hi_addr;
         assign sel       = en;
      end else begin : g_multi
         for (genvar i = 0; i < CELLS; i++) begin : g_sel
            assign sel[i] = en && (hi_addr == HI_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/lut_dram_bank.sv
// One cell of storage: an addressed one-bit write, or a serial shift.
module lut_dram_bank #(
   parameter int                     CELL_AW = 5,
   parameter int                     DEPTH   = 1 << CELL_AW,
   parameter logic [DEPTH-1:0]       INIT    = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic               shift_en,
   input  logic [CELL_AW-1:0] bit_addr,
   input  logic               din,
   input  logic               shift_in,
   output logic [DEPTH-1:0]   contents
);
   logic [DEPTH-1:0] store;
   logic [DEPTH-1:0] bit_hit;

   // write address decoder
   generate
      for (genvar j = 0; j < DEPTH; j++) begin : g_dec
         assign bit_hit[j] = wr_stb && (bit_addr == CELL_AW'(j));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store <= INIT;
      end else if (shift_en) begin
         store <= {store[DEPTH-2:0], shift_in};
      end else begin
         for (int j = 0; j < DEPTH; j++) begin
            if (bit_hit[j]) store[j] <= din;
         end
      end
   end

   assign contents = store;
endmodule

// File: rtl/lut_dram_cell.sv
module lut_dram_cell
   import lut_dram_pkg::*;
#(
   parameter int CELL_AW = 5,
   parameter int CELLS   = 2,
   parameter logic [(CELLS << CELL_AW)-1:0] INIT = 64'hA5C3_0F96_3C5A_F00D,
   localparam int SEL_W  = (CELLS > 1) ? $clog2(CELLS) : 0,
   localparam int ADDR_W = CELL_AW + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              wr_data,
   output logic              rd_data,
   output logic              casc_out
);
   localparam int DEPTH = 1 << CELL_AW;
   localparam int TOTAL = CELLS * DEPTH;
   localparam int HI_W  = (SEL_W > 0) ? SEL_W : 1;

   generate
      if (CELLS < 1 || CELLS > 2) begin : g_bad_cells
         $error("lut_dram_cell: CELLS must be 1 or 2");
      end
      if (CELL_AW < 2 || CELL_AW > 5) begin : g_bad_aw
         $error("lut_dram_cell: CELL_AW must lie in 2..5");
      end
   endgenerate

   cell_mode_e       mode_q;
   logic             ram_wr;
   logic             shift_en;
   logic [HI_W-1:0]  hi_addr;
   logic [CELLS-1:0] cell_sel;
   logic [TOTAL-1:0] mem_view;

   assign mode_q   = cell_mode_e'(mode);
   assign ram_wr   = wr_en && (mode_q == MODE_RAM);
   assign shift_en = wr_en && (mode_q == MODE_SHIFT);

   generate
      if (SEL_W > 0) begin : g_hi
         assign hi_addr = addr[ADDR_W-1 -: HI_W];
      end else begin : g_nohi
         assign hi_addr = '0;
      end
   endgenerate

   lut_dram_csel #(.CELLS(CELLS), .HI_W(HI_W)) u_csel (
      .hi_addr (hi_addr),
      .en      (ram_wr),
      .sel     (cell_sel)
   );

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_bank
         logic ser_in;
         if (i == 0) begin : g_head
            assign ser_in = wr_data;
         end else begin : g_link
            assign ser_in = mem_view[i*DEPTH-1];
         end
         lut_dram_bank #(
            .CELL_AW (CELL_AW),
            .DEPTH   (DEPTH),
            .INIT    (INIT[i*DEPTH +: DEPTH])
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (cell_sel[i]),
            .shift_en (shift_en),
            .bit_addr (addr[CELL_AW-1:0]),
            .din      (wr_data),
            .shift_in (ser_in),
            .contents (mem_view[i*DEPTH +: DEPTH])
         );
      end
   endgenerate

   // truth-table read path: the address indexes the array directly
   assign rd_data  = mem_view[addr];
   assign casc_out = mem_view[TOTAL-1];
endmodule

// File: rtl/lut_dram_cell_chk.sv
module lut_dram_cell_chk #(
   parameter int TOTAL  = 64,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              wr_data,
   input logic              casc_out,
   input logic [TOTAL-1:0]  mem_view
);
   // R2: a RAM write lands at the sampled address
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && wr_en) |=> (mem_view[$past(addr)] == $past(wr_data)));

   // R3: look-up modes ignore the write strobe
   a_r3_lut_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] == mode[0]) |=> $stable(mem_view));

   // R4: a RAM write flips at most one entry
   a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && wr_en) |=> ($countones(mem_view ^ $past(mem_view)) <= 1));

   // R5: shift moves the whole array up by one and takes the serial bit
   a_r5_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && wr_en) |=>
         (mem_view == {$past(mem_view[TOTAL-2:0]), $past(wr_data)}));

   // R6: cascade output carries the entry that was just below the top
   a_r6_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && wr_en) |=> (casc_out == $past(mem_view[TOTAL-2])));

   // R7: no enable, no change
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mem_view));
endmodule

bind lut_dram_cell lut_dram_cell_chk #(.TOTAL(TOTAL), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .addr     (addr),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .casc_out (casc_out),
   .mem_view (mem_view)
);

// File: tb/lut_dram_cell_test.sv
module lut_dram_cell_test;
   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 6;
   localparam int          N          = 64;
   localparam logic [63:0] INIT_V     = 64'hA5C3_0F96_3C5A_F00D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic          wr_data = 1'b0;
   logic          rd_data;
   logic          casc_out;

   logic [N-1:0]  exp_mem;
   int            n_vec = 0;
   int            n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lut_dram_cell #(.CELL_AW(5), .CELLS(2), .INIT(INIT_V)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .casc_out(casc_out)
   );

   task automatic check(input string req, input logic act, input logic exp, input int a);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%0d actual=%b expected=%b", req, a, act, exp);
      end
   endtask

   // read every address with no clock in between reads
   task automatic sweep(input string req, input logic [1:0] m);
      @(negedge clk);
      wr_en = 1'b0;
      mode  = m;
      for (int a = 0; a < N; a++) begin
         addr = AW'(a);
         #1;
         check(req, rd_data, exp_mem[a], a);
      end
      check({req, " casc"}, casc_out, exp_mem[N-1], N-1);
   endtask

   // one clock edge with given inputs; model updated from the requirements
   task automatic edge_op(input logic [1:0] m, input int a, input logic d, input logic en);
      @(negedge clk);
      mode = m; addr = AW'(a); wr_data = d; wr_en = en;
      @(posedge clk);
      if (en && m == 2'b01) exp_mem[a] = d;
      else if (en && m == 2'b10) exp_mem = {exp_mem[N-2:0], d};
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      exp_mem = INIT_V;
      repeat (3) @(posedge clk);
      // R1: reset contents visible during reset
      @(negedge clk);
      addr = 6'd13; #1;
      check("R1 in reset", rd_data, INIT_V[13], 13);
      @(negedge clk);
      rst_n = 1'b1;
      sweep("R1 lut read", 2'b00);

      // R3: write strobes in both look-up modes do nothing
      for (int a = 0; a < N; a += 5) edge_op(2'b00, a, ~INIT_V[a], 1'b1);
      for (int a = 2; a < N; a += 7) edge_op(2'b11, a, ~INIT_V[a], 1'b1);
      sweep("R3 lut ignores write", 2'b00);

      // R2: write an arithmetic pattern over all entries
      for (int a = 0; a < N; a++) edge_op(2'b01, a, logic'(((a * 7 + 3) % 5) < 2), 1'b1);
      sweep("R2 ram pattern", 2'b01);

      // R2: read-after-write at the same address, next cycle
      edge_op(2'b01, 40, ~exp_mem[40], 1'b1);
      check("R2 read after write", rd_data, exp_mem[40], 40);

      // R4: single writes in lower and upper cell touch only their entry
      edge_op(2'b01, 9, ~exp_mem[9], 1'b1);
      sweep("R4 lower cell write", 2'b01);
      edge_op(2'b01, 9 + 32, ~exp_mem[41], 1'b1);
      sweep("R4 upper cell write", 2'b01);

      // R7: enable low holds in RAM and shift modes
      for (int a = 0; a < 8; a++) edge_op(2'b01, a, ~exp_mem[a], 1'b0);
      for (int a = 0; a < 8; a++) edge_op(2'b10, a, 1'b1, 1'b0);
      sweep("R7 idle hold", 2'b10);

      // R8: contents survive mode switches
      sweep("R8 mode to lut", 2'b00);
      sweep("R8 mode to lut2", 2'b11);

      // R5/R6: shift 80 bits through a tap at 17; check tap and cascade each edge
      for (int n = 0; n < 80; n++) begin
         edge_op(2'b10, 17, logic'(((n * 5 + 1) % 3) == 0), 1'b1);
         check("R5 delay tap", rd_data, exp_mem[17], 17);
         check("R6 cascade", casc_out, exp_mem[N-1], N-1);
      end
      sweep("R5 shift contents", 2'b10);
      // R5: taps at edges of the cell boundary after one more shift
      edge_op(2'b10, 31, 1'b1, 1'b1);
      check("R5 tap 31", rd_data, exp_mem[31], 31);
      @(negedge clk); wr_en = 1'b0; addr = 6'd32; #1;
      check("R5 tap 32", rd_data, exp_mem[32], 32);
      sweep("R8 shift to ram", 2'b01);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule